// File: doc/BRIEF.md
# Crosspoint Switch Programming Controller

This block holds and applies the routing for a 16-output by 16-input crosspoint switch. Every output row either routes exactly one input through to the output or is switched off entirely. New routing is staged first in a holding bank of per-output setting words, which can be loaded in two ways: as one long serial stream, or by writing one output's word at a time through an addressed port. A single update strobe then transfers the whole holding bank into the live bank in one clock edge. The live bank is decoded into a 256-bit crosspoint enable grid, so the switch fabric sees the change on all outputs at once.

The serial stream passes through the holding bank and leaves on a serial output pin. Several devices can therefore share one data line, with the serial output of one device wired to the serial input of the next. Reset disables every output in both banks. Several devices can then drive a shared output bus with no conflict until software has programmed them.

Top module: `xbar_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), and right after it is released, every bit of xp_en is 0 and ser_out is 0.
- R2: On a clock edge where upd is 1, the live bank takes every output's holding-bank word at once. xp_en shows the new routing directly after that edge.
- R3: On a clock edge where upd is 0, xp_en does not change, whatever serial shifting or parallel writes happen.
- R4: A setting word is 5 bits wide: bit 4 is the enable and bits 3:0 are the input index. When output o is enabled with index i, only xp_en[o*16+i] is set in row o, bits o*16 to o*16+15.
- R5: When output o's live word has enable 0, all 16 bits of row o in xp_en are 0.
- R6: A clock edge with wr_en 1 and ser_en 0 writes wr_data into the holding-bank entry of output wr_addr. The other entries keep their values.
- R7: A clock edge with ser_en 1 shifts ser_in into the 80-bit holding chain. Chain bit 5*o+b holds bit b of output o's word. A new bit enters at chain bit 0, and every bit moves one place up. After 80 shifts, the first bit sent sits in bit 4 of output 15.
- R8: ser_out always shows chain bit 79, which is the enable bit of output 15. So a bit sent on ser_in comes out on ser_out 80 shift edges later, for daisy-chaining.
- R9: When ser_en and wr_en are both 1 on the same edge, the shift takes place and the parallel write is ignored.
- R10: Reset also clears the holding bank. An update right after reset leaves every output disabled.
- R11: When upd is 1 on the same edge as a load, the live bank takes the holding-bank contents from before that load. The load only appears at a later update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_en | input | 1 | Shift the holding chain on this edge |
| ser_in | input | 1 | Serial data into chain bit 0 |
| ser_out | output | 1 | Chain bit 79, for daisy-chaining |
| wr_en | input | 1 | Parallel write strobe |
| wr_addr | input | 4 | Output whose holding entry is written |
| wr_data | input | 5 | Setting word: bit 4 enable, bits 3:0 input index |
| upd | input | 1 | Global update: holding bank to live bank |
| xp_en | output | 256 | Crosspoint enables, row o at bits o*16 to o*16+15 |

## Verification
The assertions assume that every control input (ser_en, wr_en, upd, ser_in, wr_addr, wr_data) is at a known level at each rising edge. They also assume that reset is released with enough margin before an edge. With 16 outputs, every 4-bit wr_addr names a real output, so no address range needs to be assumed. The stimulus changes all inputs 1 ns after the falling edge and releases reset at that same point, so they have settled well before the next rising edge. Random values are drawn only within the declared port widths.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int XB_OUTS = 16;
    localparam int XB_INS  = 16;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_WRITE = 2'd2
    } load_op_e;
endpackage

// File: rtl/xbar_rank1.sv
module xbar_rank1 #(
    parameter int N_OUT = xbar_pkg::XB_OUTS,
    parameter int N_IN  = xbar_pkg::XB_INS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_en,
    input  logic                       ser_in,
    input  logic                       wr_en,
    input  logic [$clog2(N_OUT)-1:0]   wr_addr,
    input  logic [$clog2(N_IN):0]      wr_data,
    output logic [N_OUT*($clog2(N_IN)+1)-1:0] chain_o,
    output logic                       ser_out
);
    import xbar_pkg::*;

    localparam int IW    = $clog2(N_IN);
    localparam int WW    = IW + 1;
    localparam int CHAIN = N_OUT * WW;

    typedef struct packed {
        load_op_e         op;
        logic [CHAIN-1:0] chain;
    } r1_t;

    r1_t r1_d;
    logic [CHAIN-1:0] chain_q;

    // Shift has priority over the addressed write
    always_comb begin
        r1_d.chain = chain_q;
        if (ser_en)
            r1_d.op = LD_SHIFT;
        else if (wr_en)
            r1_d.op = LD_WRITE;
        else
            r1_d.op = LD_IDLE;
        case (r1_d.op)
            LD_SHIFT: r1_d.chain = {chain_q[CHAIN-2:0], ser_in};
            LD_WRITE: r1_d.chain[int'(wr_addr)*WW +: WW] = wr_data;
            default:  r1_d.chain = chain_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= r1_d.chain;
    end

    assign chain_o = chain_q;
    assign ser_out = chain_q[CHAIN-1];
endmodule

// File: rtl/xbar_rank2.sv
module xbar_rank2 #(
    parameter int N_OUT = xbar_pkg::XB_OUTS,
    parameter int N_IN  = xbar_pkg::XB_INS
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   upd,
    input  logic [N_OUT*($clog2(N_IN)+1)-1:0]      hold_i,
    output logic [N_OUT*($clog2(N_IN)+1)-1:0]      live_o
);
    localparam int WW    = $clog2(N_IN) + 1;
    localparam int CHAIN = N_OUT * WW;

    typedef struct packed {
        logic [CHAIN-1:0] live;
    } r2_t;

    r2_t r2_d;
    r2_t r2_q;

    always_comb begin
        r2_d = r2_q;
        if (upd)
            r2_d.live = hold_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r2_q <= '0;
        else
            r2_q <= r2_d;
    end

    assign live_o = r2_q.live;
endmodule

// File: rtl/xbar_grid.sv
module xbar_grid #(
    parameter int N_OUT = xbar_pkg::XB_OUTS,
    parameter int N_IN  = xbar_pkg::XB_INS
) (
    input  logic [N_OUT*($clog2(N_IN)+1)-1:0] live_i,
    output logic [N_OUT*N_IN-1:0]             grid_o
);
    localparam int IW = $clog2(N_IN);
    localparam int WW = IW + 1;

    for (genvar o = 0; o < N_OUT; o++) begin : g_row
        logic          row_on;
        logic [IW-1:0] row_idx;
        assign row_on  = live_i[o*WW + IW];
        assign row_idx = live_i[o*WW +: IW];
        for (genvar i = 0; i < N_IN; i++) begin : g_col
            assign grid_o[o*N_IN + i] = row_on && (row_idx == IW'(i));
        end
    end
endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl #(
    parameter int N_OUT = xbar_pkg::XB_OUTS,
    parameter int N_IN  = xbar_pkg::XB_INS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_en,
    input  logic                      ser_in,
    output logic                      ser_out,
    input  logic                      wr_en,
    input  logic [$clog2(N_OUT)-1:0]  wr_addr,
    input  logic [$clog2(N_IN):0]     wr_data,
    input  logic                      upd,
    output logic [N_OUT*N_IN-1:0]     xp_en
);
    localparam int WW    = $clog2(N_IN) + 1;
    localparam int CHAIN = N_OUT * WW;

    logic [CHAIN-1:0] rank1_w;
    logic [CHAIN-1:0] active_w;

    xbar_rank1 #(.N_OUT(N_OUT), .N_IN(N_IN)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_en  (ser_en),
        .ser_in  (ser_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .chain_o (rank1_w),
        .ser_out (ser_out)
    );

    xbar_rank2 #(.N_OUT(N_OUT), .N_IN(N_IN)) u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd),
        .hold_i (rank1_w),
        .live_o (active_w)
    );

    xbar_grid #(.N_OUT(N_OUT), .N_IN(N_IN)) u_grid (
        .live_i (active_w),
        .grid_o (xp_en)
    );
endmodule

// File: rtl/xbar_ctrl_chk.sv
module xbar_ctrl_chk #(
    parameter int N_OUT = xbar_pkg::XB_OUTS,
    parameter int N_IN  = xbar_pkg::XB_INS
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   ser_en,
    input logic                                   ser_in,
    input logic                                   wr_en,
    input logic [$clog2(N_OUT)-1:0]               wr_addr,
    input logic                                   upd,
    input logic                                   ser_out,
    input logic [N_OUT*N_IN-1:0]                  xp_en,
    input logic [N_OUT*($clog2(N_IN)+1)-1:0]      rank1,
    input logic [N_OUT*($clog2(N_IN)+1)-1:0]      active
);
    localparam int IW    = $clog2(N_IN);
    localparam int WW    = IW + 1;
    localparam int AW    = $clog2(N_OUT);
    localparam int CHAIN = N_OUT * WW;

    // R3: live grid only moves on an update edge
    p_hold_no_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(xp_en));

    // R2: update takes the whole holding bank
    p_update_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (active == $past(rank1)));

    // R7: shift moves the chain up by one and takes ser_in at the bottom
    p_shift_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |=> (rank1[0] == $past(ser_in)) &&
                   (rank1[CHAIN-1:1] == $past(rank1[CHAIN-2:0])));

    // R8: serial output holds unless a shift or a write to the top entry happens
    p_serout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && !(wr_en && wr_addr == AW'(N_OUT-1))) |=> $stable(ser_out));

    for (genvar o = 0; o < N_OUT; o++) begin : g_row_chk
        // R4: at most one crosspoint per output row
        p_row_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(xp_en[o*N_IN +: N_IN]));

        // R4: an enabled row drives the indexed input
        p_row_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
            active[o*WW + IW] |-> xp_en[o*N_IN + int'(active[o*WW +: IW])]);

        // R5: a disabled row is empty
        p_row_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !active[o*WW + IW] |-> (xp_en[o*N_IN +: N_IN] == '0));
    end
endmodule

bind xbar_ctrl xbar_ctrl_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_en  (ser_en),
    .ser_in  (ser_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .upd     (upd),
    .ser_out (ser_out),
    .xp_en   (xp_en),
    .rank1   (rank1_w),
    .active  (active_w)
);

// File: tb/xbar_ctrl_test.sv
`timescale 1ns/1ps
module xbar_ctrl_test;
    localparam int NO = 16;
    localparam int NI = 16;
    localparam int CH = 80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_en = 1'b0;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [4:0]   wr_data = '0;
    logic         upd = 1'b0;
    logic [255:0] xp_en;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    started  = 0;
    bit    finished = 0;
    string cur_req  = "R1";

    // behavioural reference: queue front is the serial output end
    bit       chain_q[$];
    bit [4:0] live_m[NO];

    always #2.5 clk = ~clk;

    xbar_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_in(ser_in),
        .ser_out(ser_out), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd(upd), .xp_en(xp_en)
    );

    function automatic bit [4:0] entry_of(int o);
        bit [4:0] e;
        for (int b = 0; b < 5; b++) e[b] = chain_q[CH-1-(5*o+b)];
        return e;
    endfunction

    function automatic void put_entry(int o, bit [4:0] e);
        for (int b = 0; b < 5; b++) chain_q[CH-1-(5*o+b)] = e[b];
    endfunction

    function automatic logic [255:0] grid_of();
        logic [255:0] g = '0;
        for (int o = 0; o < NO; o++)
            if (live_m[o][4]) g[o*NI + live_m[o][3:0]] = 1'b1;
        return g;
    endfunction

    task automatic model_reset();
        chain_q.delete();
        for (int k = 0; k < CH; k++) chain_q.push_back(1'b0);
        for (int o = 0; o < NO; o++) live_m[o] = '0;
    endtask

    always @(posedge clk) begin
        bit [4:0] snap[NO];
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int o = 0; o < NO; o++) snap[o] = entry_of(o);
            if (ser_en) begin
                void'(chain_q.pop_front());
                chain_q.push_back(ser_in);
            end else if (wr_en) begin
                put_entry(int'(wr_addr), wr_data);
            end
            if (upd)
                for (int o = 0; o < NO; o++) live_m[o] = snap[o];
        end
        started = 1;
    end

    task automatic check_grid(string req, logic [255:0] exp_g);
        n_checks++;
        if (xp_en !== exp_g) begin
            n_fail++;
            $display("FAIL %s xp_en actual=%h expected=%h", req, xp_en, exp_g);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp_b);
        n_checks++;
        if (act !== exp_b) begin
            n_fail++;
            $display("FAIL %s ser_out actual=%b expected=%b", req, act, exp_b);
        end
    endtask

    // per-cycle comparison against the reference, on the falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            check_grid(cur_req, grid_of());
            check_bit(cur_req, ser_out, chain_q[0]);
        end
    end

    task automatic idle();
        ser_en = 0; wr_en = 0; upd = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pwrite(int o, bit [4:0] d, bit u);
        ser_en = 0; wr_en = 1; wr_addr = 4'(o); wr_data = d; upd = u;
        step();
        idle();
    endtask

    task automatic do_upd();
        upd = 1; step(); upd = 0;
    endtask

    task automatic shift_bit(bit b);
        ser_en = 1; ser_in = b; step(); ser_en = 0;
    endtask

    initial begin
        logic [79:0] pat;
        // R1: reset state
        cur_req = "R1";
        repeat (3) step();
        check_grid("R1", '0);
        check_bit("R1", ser_out, 1'b0);
        rst_n = 1; step();
        check_grid("R1", '0);

        // R6 / R3: parallel writes, no update
        cur_req = "R6_R3";
        pwrite(3, 5'h17, 0);
        pwrite(0, 5'h1F, 0);
        pwrite(15, 5'h12, 0);
        pwrite(9, 5'h05, 0);
        check_grid("R3", '0);
        step();

        // R2 / R4 / R5: apply
        cur_req = "R2_R4_R5";
        do_upd(); step();
        begin
            logic [255:0] e = '0;
            e[3*16+7] = 1; e[0*16+15] = 1; e[15*16+2] = 1;
            check_grid("R4", e);
            check_grid("R5", e);
        end
        check_bit("R8", ser_out, 1'b1);

        // R6: rewrite one entry, only it changes after update
        cur_req = "R6";
        pwrite(3, 5'h10, 0);
        do_upd(); step();
        begin
            logic [255:0] e = '0;
            e[3*16+0] = 1; e[0*16+15] = 1; e[15*16+2] = 1;
            check_grid("R6", e);
        end

        // R7 / R8: full 80-bit serial load, ser_out compared each cycle
        cur_req = "R7_R8";
        pat = {$urandom, $urandom, $urandom};
        for (int k = 79; k >= 0; k--) shift_bit(pat[k]);
        check_grid("R3", grid_of());
        do_upd(); step();
        begin
            logic [255:0] e = '0;
            for (int o = 0; o < NO; o++)
                if (pat[5*o+4]) e[o*16 + pat[5*o +: 4]] = 1;
            check_grid("R7", e);
        end

        // R8: daisy-chain delay, mark bit emerges after 80 shifts
        cur_req = "R8";
        shift_bit(1'b1);
        for (int k = 0; k < 79; k++) shift_bit(1'b0);
        check_bit("R8", ser_out, 1'b1);
        shift_bit(1'b0);
        check_bit("R8", ser_out, 1'b0);

        // R9: shift and write together, write ignored
        cur_req = "R9";
        ser_en = 1; ser_in = 1; wr_en = 1; wr_addr = 4'd0; wr_data = 5'h1A;
        step(); idle();
        do_upd(); step();
        check_grid("R9", grid_of());

        // R11: update in the same edge as a load
        cur_req = "R11";
        pwrite(6, 5'h1C, 1);
        step();
        check_grid("R11", grid_of());
        do_upd(); step();
        check_grid("R11", grid_of());

        // random mix
        cur_req = "R2_R3_R6_R7";
        for (int k = 0; k < 400; k++) begin
            ser_en = ($urandom % 4) == 0;
            ser_in = $urandom;
            wr_en = $urandom;
            wr_addr = $urandom;
            wr_data = $urandom;
            upd = ($urandom % 8) == 0;
            step();
        end
        idle(); step();

        // R10: reset mid-run, then update
        cur_req = "R10";
        rst_n = 0; step(); step();
        rst_n = 1; step();
        do_upd(); step();
        check_grid("R10", '0);
        check_bit("R10", ser_out, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule